// File: doc/BRIEF.md
# Chained Bus Grant Requester

This block lets a local DMA engine borrow a shared bus from a higher-priority master. The bus uses a request, grant and acknowledge handshake. The request and acknowledge lines are shared, active-low and open-drain, so every participant can only pull them low or let them float high. The grant line is not shared. It runs as a serial priority chain from master to master.

When the engine raises its request, the block pulls the shared request line and waits for a grant on its chain input. It waits as long as the upstream master takes to finish its current cycle. Once the grant is present and the bus is seen free, it pulls the acknowledge line, drops its request and tells the engine it owns the bus. When the engine reports completion, the block lets go of acknowledge and ownership passes back up the chain.

While the block neither requests nor owns the bus, it forwards the grant it receives to the next lower-priority master. A separate command makes it hold the bus reset line low for a long, fixed number of clock periods.

All open-drain outputs are modelled as pull enables: a 1 means the pin is pulled low, and a 0 means it is released.

Top module: `chain_bus_requester`

## Requirements
- R1: After synchronous reset, the block releases all three pull outputs (`req_pull`, `ack_pull`, `busrst_pull` are 0). It also holds `grant_out_n` at 1 and keeps `owner` and `owned_pulse` at 0.
- R2: One clock edge after `eng_req` is seen in the idle state, `req_pull` becomes 1. While `req_pull` or `ack_pull` is 1, `grant_out_n` stays 1.
- R3: While the synchronized `grant_in_n` stays 1, the block keeps requesting for any number of cycles and never raises `ack_pull`.
- R4: The block raises `ack_pull` only after `grant_in_n`, `ack_in_n` and `strobe_in_n` have been seen, through two-flop synchronizers, as 0, 1 and 1 respectively. `req_pull` falls on the same edge that `ack_pull` rises. When the grant falls while the request is already out and the bus is free, `ack_pull` rises on the fourth clock edge. When the bus becomes free while the grant is already held, `ack_pull` rises on the third clock edge.
- R5: On the edge that gives ownership, `owned_pulse` is 1 for exactly one cycle. `owner` stays 1 until `eng_done` is seen. On the next edge `owner` and `ack_pull` return to 0.
- R6: In the idle or bus-reset states, `grant_out_n` follows `grant_in_n` with a delay of three clock edges.
- R7: When `eng_rst_cmd` is seen in the idle state, `busrst_pull` is 1 for exactly 512 consecutive cycles (parameter `RST_CYCLES`). During those cycles neither `req_pull` nor `ack_pull` is 1. The block then returns to idle.
- R8: `eng_rst_cmd` has no effect while the block owns the bus. `busrst_pull` stays 0 during ownership and after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_req | input | 1 | Local engine asks for the bus |
| eng_done | input | 1 | Local engine has finished its bus cycles |
| eng_rst_cmd | input | 1 | Command to issue a long bus reset pulse |
| grant_in_n | input | 1 | Grant from the next master up the chain, asynchronous, active low |
| ack_in_n | input | 1 | Sensed level of the shared acknowledge line, asynchronous, active low |
| strobe_in_n | input | 1 | Sensed bus address strobe, asynchronous, active low |
| req_pull | output | 1 | Pull enable for the shared request line |
| ack_pull | output | 1 | Pull enable for the shared acknowledge line |
| grant_out_n | output | 1 | Grant passed to lower-priority masters, active low |
| owned_pulse | output | 1 | One-cycle strobe when ownership starts |
| owner | output | 1 | Level flag, high while the engine owns the bus |
| busrst_pull | output | 1 | Pull enable for the bus reset line |

## Verification
A stuck or wrong state shows within a few edges at the ports. Examples are a request that never drops, an acknowledge raised without a synchronized grant, or a grant forwarded while the block itself competes for the bus. The bench checks the exact edge on which each output changes after a stimulus: three edges for grant forwarding, four for claiming a free bus, one for release. An off-by-one in the synchronizer depth or the decode of the next state therefore fails immediately. The reset pulse width is checked on both its last high cycle and its first low cycle, so a counter error of one cycle is also visible.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQUEST   = 3'd1,
    ST_WAIT_FREE = 3'd2,
    ST_OWN       = 3'd3,
    ST_RELEASE   = 3'd4,
    ST_RST_PULSE = 3'd5
  } bgc_state_t;

  // bit positions of the synchronized input bundle
  localparam int SYN_GNT = 0;
  localparam int SYN_ACK = 1;
  localparam int SYN_AS  = 2;
  localparam int SYN_W   = 3;

endpackage

// File: rtl/bgc_sync.sv
module bgc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '1;
        else     pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '1;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/bgc_timer.sv
module bgc_timer #(
  parameter int LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic last
);

  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= CW'(LEN - 1);
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/chain_bus_requester.sv
module chain_bus_requester
  import bgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic eng_req,
  input  logic eng_done,
  input  logic eng_rst_cmd,
  input  logic grant_in_n,
  input  logic ack_in_n,
  input  logic strobe_in_n,
  output logic req_pull,
  output logic ack_pull,
  output logic grant_out_n,
  output logic owned_pulse,
  output logic owner,
  output logic busrst_pull
);

  bgc_state_t st_q, st_d;

  logic [SYN_W-1:0] raw_in, syn_in;
  logic gnt_s, ack_s, as_s;
  logic tmr_load, tmr_run, tmr_last;

  assign raw_in[SYN_GNT] = grant_in_n;
  assign raw_in[SYN_ACK] = ack_in_n;
  assign raw_in[SYN_AS]  = strobe_in_n;

  bgc_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  assign gnt_s = syn_in[SYN_GNT];
  assign ack_s = syn_in[SYN_ACK];
  assign as_s  = syn_in[SYN_AS];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (eng_rst_cmd)  st_d = ST_RST_PULSE;
        else if (eng_req) st_d = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (!gnt_s) st_d = ST_WAIT_FREE;
      end
      ST_WAIT_FREE: begin
        if (gnt_s)             st_d = ST_REQUEST;
        else if (ack_s && as_s) st_d = ST_OWN;
      end
      ST_OWN: begin
        if (eng_done) st_d = ST_RELEASE;
      end
      ST_RELEASE:   st_d = ST_IDLE;
      ST_RST_PULSE: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_q == ST_IDLE) && (st_d == ST_RST_PULSE);
  assign tmr_run  = (st_q == ST_RST_PULSE);

  bgc_timer #(.LEN(RST_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .run  (tmr_run),
    .last (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      req_pull    <= 1'b0;
      ack_pull    <= 1'b0;
      owner       <= 1'b0;
      owned_pulse <= 1'b0;
      busrst_pull <= 1'b0;
      grant_out_n <= 1'b1;
    end else begin
      st_q        <= st_d;
      req_pull    <= (st_d == ST_REQUEST) || (st_d == ST_WAIT_FREE);
      ack_pull    <= (st_d == ST_OWN);
      owner       <= (st_d == ST_OWN);
      owned_pulse <= (st_d == ST_OWN) && (st_q != ST_OWN);
      busrst_pull <= (st_d == ST_RST_PULSE);
      grant_out_n <= ((st_d == ST_IDLE) || (st_d == ST_RST_PULSE)) ? gnt_s : 1'b1;
    end
  end

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
  parameter int RST_CYCLES = 512
) (
  input logic clk,
  input logic rst,
  input logic gnt_s,
  input logic ack_s,
  input logic as_s,
  input logic req_pull,
  input logic ack_pull,
  input logic grant_out_n,
  input logic owned_pulse,
  input logic owner,
  input logic busrst_pull
);

  localparam int RW = $clog2(RST_CYCLES + 2) + 1;

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)              run_len <= '0;
    else if (busrst_pull) run_len <= run_len + 1'b1;
    else                  run_len <= '0;
  end

  a_r2_gout_hold: assert property (@(posedge clk) disable iff (rst)
    (req_pull || ack_pull) |-> grant_out_n);

  a_r4_ack_needs_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pull) |-> ($past(gnt_s) == 1'b0) && $past(ack_s) && $past(as_s));

  a_r4_req_dropped: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_pull) |-> !req_pull);

  a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
    owned_pulse |=> !owned_pulse);

  a_r5_pulse_with_owner: assert property (@(posedge clk) disable iff (rst)
    owned_pulse |-> owner && ack_pull);

  a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
    busrst_pull |-> !req_pull && !ack_pull);

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(busrst_pull) |-> (run_len == RW'(RST_CYCLES)));

  a_r8_no_reset_when_owner: assert property (@(posedge clk) disable iff (rst)
    owner |=> !busrst_pull);

endmodule

bind chain_bus_requester bgc_checker #(.RST_CYCLES(RST_CYCLES)) u_bgc_chk (
  .clk         (clk),
  .rst         (rst),
  .gnt_s       (gnt_s),
  .ack_s       (ack_s),
  .as_s        (as_s),
  .req_pull    (req_pull),
  .ack_pull    (ack_pull),
  .grant_out_n (grant_out_n),
  .owned_pulse (owned_pulse),
  .owner       (owner),
  .busrst_pull (busrst_pull)
);

// File: tb/chain_bus_requester_test.sv
`timescale 1ns/1ps
module chain_bus_requester_test;

  localparam int RSTC = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eng_req = 1'b0, eng_done = 1'b0, eng_rst_cmd = 1'b0;
  logic grant_in_n = 1'b1, ack_in_n = 1'b1, strobe_in_n = 1'b1;
  logic req_pull, ack_pull, grant_out_n, owned_pulse, owner, busrst_pull;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chain_bus_requester #(.SYNC_STAGES(2), .RST_CYCLES(RSTC)) uut (
    .clk(clk), .rst(rst), .eng_req(eng_req), .eng_done(eng_done),
    .eng_rst_cmd(eng_rst_cmd), .grant_in_n(grant_in_n), .ack_in_n(ack_in_n),
    .strobe_in_n(strobe_in_n), .req_pull(req_pull), .ack_pull(ack_pull),
    .grant_out_n(grant_out_n), .owned_pulse(owned_pulse), .owner(owner),
    .busrst_pull(busrst_pull)
  );

  // edges from grant falling (request out, bus free) to ownership
  function automatic int own_latency();
    return 2 + 1 + 1; // two sync flops, REQUEST->WAIT_FREE, WAIT_FREE->OWN
  endfunction

  // edges from a grant change to the forwarded grant in idle
  function automatic int pass_latency();
    return 2 + 1;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_ownership();
    eng_req = 1'b0;
    eng_done = 1'b1;
    tick(1);
    eng_done = 1'b0;
    grant_in_n = 1'b1;
    tick(4);
  endtask

  initial begin
    void'($urandom(32'h1357_2468));
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 req_pull", req_pull, 1'b0);
    chk("R1 ack_pull", ack_pull, 1'b0);
    chk("R1 busrst_pull", busrst_pull, 1'b0);
    chk("R1 grant_out_n", grant_out_n, 1'b1);
    chk("R1 owner", owner, 1'b0);
    chk("R1 owned_pulse", owned_pulse, 1'b0);

    // R6 grant pass-through in idle
    grant_in_n = 1'b0;
    tick(pass_latency() - 1);
    chk("R6 gout before latency", grant_out_n, 1'b1);
    tick(1);
    chk("R6 gout follows low", grant_out_n, 1'b0);
    grant_in_n = 1'b1;
    tick(pass_latency());
    chk("R6 gout follows high", grant_out_n, 1'b1);

    // R2/R3/R4/R5 directed handshake with a long grant delay
    eng_req = 1'b1;
    tick(1);
    chk("R2 req after one edge", req_pull, 1'b1);
    chk("R2 gout held", grant_out_n, 1'b1);
    tick(40);
    chk("R3 still requesting", req_pull, 1'b1);
    chk("R3 no ack without grant", ack_pull, 1'b0);
    grant_in_n = 1'b0;
    tick(own_latency() - 1);
    chk("R4 no ack before latency", ack_pull, 1'b0);
    chk("R2 gout held while requesting", grant_out_n, 1'b1);
    tick(1);
    chk("R4 ack raised", ack_pull, 1'b1);
    chk("R4 req dropped", req_pull, 1'b0);
    chk("R5 owner set", owner, 1'b1);
    chk("R5 pulse set", owned_pulse, 1'b1);
    eng_req = 1'b0;
    tick(1);
    chk("R5 pulse single", owned_pulse, 1'b0);
    chk("R5 owner held", owner, 1'b1);
    eng_done = 1'b1;
    tick(1);
    eng_done = 1'b0;
    chk("R5 owner cleared", owner, 1'b0);
    chk("R5 ack released", ack_pull, 1'b0);
    grant_in_n = 1'b1;
    tick(4);

    // R4 bus busy: grant held but acknowledge line low
    ack_in_n = 1'b0;
    eng_req = 1'b1;
    grant_in_n = 1'b0;
    tick(8);
    chk("R4 busy no ack", ack_pull, 1'b0);
    chk("R4 busy still requesting", req_pull, 1'b1);
    ack_in_n = 1'b1;
    tick(2);
    chk("R4 busy clear, not yet", ack_pull, 1'b0);
    tick(1);
    chk("R4 claims after free", ack_pull, 1'b1);

    // R8 reset command while owning
    eng_rst_cmd = 1'b1;
    tick(1);
    eng_rst_cmd = 1'b0;
    tick(3);
    chk("R8 no pulse while owner", busrst_pull, 1'b0);
    chk("R8 still owner", owner, 1'b1);
    finish_ownership();
    chk("R8 no pulse after release", busrst_pull, 1'b0);
    chk("R8 idle no request", req_pull, 1'b0);

    // R7 reset pulse width
    eng_rst_cmd = 1'b1;
    tick(1);
    eng_rst_cmd = 1'b0;
    chk("R7 pulse starts", busrst_pull, 1'b1);
    tick(RSTC - 2);
    chk("R7 pulse still high", busrst_pull, 1'b1);
    chk("R7 no request during pulse", req_pull, 1'b0);
    chk("R6 gout during pulse", grant_out_n, 1'b1);
    tick(1);
    chk("R7 last high cycle", busrst_pull, 1'b1);
    tick(1);
    chk("R7 pulse ended", busrst_pull, 1'b0);
    eng_req = 1'b1;
    tick(1);
    chk("R7 back to idle accepts request", req_pull, 1'b1);
    eng_req = 1'b0;
    grant_in_n = 1'b0;
    tick(own_latency());
    finish_ownership();

    // random handshakes
    for (int t = 0; t < 30; t++) begin
      int gd;
      int dd;
      gd = $urandom_range(0, 30);
      dd = $urandom_range(1, 12);
      eng_req = 1'b1;
      tick(1);
      chk("R2 random req", req_pull, 1'b1);
      if (gd > 0) begin
        tick(gd);
        chk("R3 random wait", ack_pull, 1'b0);
      end
      grant_in_n = 1'b0;
      tick(own_latency() - 1);
      chk("R4 random early", owner, 1'b0);
      tick(1);
      chk("R4 random claim", ack_pull, 1'b1);
      chk("R5 random pulse", owned_pulse, 1'b1);
      eng_req = 1'b0;
      tick(dd);
      chk("R5 random hold", owner, 1'b1);
      chk("R5 random pulse gone", owned_pulse, 1'b0);
      eng_done = 1'b1;
      tick(1);
      eng_done = 1'b0;
      chk("R5 random release", ack_pull, 1'b0);
      grant_in_n = 1'b1;
      tick(4);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule